// File: doc/BRIEF.md
# Rate-Paced Pin Streaming Buffer with RAM Port Arbitration

This block sits between one processing core, the core's slot on a shared RAM port, and a 32-bit group of I/O pins. It moves a continuous stream between pins and RAM through a small circular buffer of up to 19 words. A 32-bit phase accumulator sets the pin-side rate: each carry out of the accumulator is one pin transfer. The fastest rate is one transfer per clock. In the pins-to-RAM direction, pin samples taken on each strobe are queued and written out to consecutive RAM addresses on every cycle the core owns the port. In the RAM-to-pins direction, the buffer prefetches from consecutive addresses whenever it has room and the port is available. Each strobe then moves the oldest word to the pin outputs.

Transfers are 8, 16 or 32 bits wide. The data sits in the low lanes, and the stream address advances by 1, 2 or 4 bytes. The same RAM slot also serves the core's ordinary word loads and stores. The stream always takes precedence. A core request is held, with the stall output high, until a cycle arrives in which the slot is available and the stream has nothing to move. Software starts a stream with a one-cycle start command and ends it with a stop command. It can watch the stream address and two sticky flags that record dropped samples and starved strobes.

Top module: `stream_fifo_arb`

## Requirements
- R1: After reset the block is idle: `stream_active`, `ram_req`, `flag_ovf`, `flag_unf` and `pin_strobe` are 0, and `pin_out` and `stream_addr` are zero.
- R2: While streaming, a 32-bit accumulator adds the loaded step once per clock, starting from zero. `pin_strobe` is high in exactly the cycles where that addition carries out of bit 31. No strobe occurs while idle or in a cycle with `cmd_start` high.
- R3: `cfg_size` encodes the transfer width: 0 is 8 bits, 1 is 16 bits, and 2 or 3 is 32 bits. Streamed data keeps only the low 8, 16 or 32 bits (the rest zero). `ram_size` carries this code on stream accesses and 2 on core accesses. `stream_addr` advances by 1, 2 or 4 after each stream access.
- R4: Pins-to-RAM (`cfg_to_ram`=1): on a strobe, `pin_in` is queued. In every cycle with `ram_avail` high and a non-empty queue, the oldest entry is written to `stream_addr`. Entries leave in the order they were taken.
- R5: RAM-to-pins (`cfg_to_ram`=0): in every cycle with `ram_avail` high and fewer than 19 entries queued, a read is issued at `stream_addr` and `ram_rdata` of that cycle is queued. On a strobe with a non-empty queue, the oldest entry appears on `pin_out` after the clock edge.
- R6: The queue holds 19 entries. A pin sample arriving while 19 entries are held and none leaves in that cycle is dropped, and `flag_ovf` is set and stays set.
- R7: A strobe in RAM-to-pins mode that finds the queue empty leaves `pin_out` unchanged, and sets `flag_unf`, which stays set.
- R8: A stream access takes the RAM slot ahead of the core. `core_stall` is high whenever `core_req` is high and either `ram_avail` is low or the stream issues an access in that cycle.
- R9: A core request that is not stalled drives `ram_req` with the core's write enable, address and write data in that cycle. `core_rdata` returns `ram_rdata` of that same cycle.
- R10: `cmd_start` empties the queue and clears both flags. It loads direction, width, base address and step, and zeroes the accumulator. The stream is active from the next cycle. The start cycle itself issues no stream access.
- R11: `cmd_stop` lets the stream activity of its own cycle complete. From the next cycle there are no stream accesses or strobes, and `stream_addr` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | One-cycle start pulse; loads the cfg_* inputs |
| cmd_stop | input | 1 | One-cycle stop pulse |
| cfg_to_ram | input | 1 | 1 = pins to RAM, 0 = RAM to pins |
| cfg_size | input | 2 | Transfer width code (0 byte, 1 half, 2/3 word) |
| cfg_base | input | ADDR_W | Stream start byte address |
| cfg_step | input | ACC_W | Accumulator increment per clock |
| pin_in | input | 32 | Pin group sampled on strobes |
| pin_out | output | 32 | Registered pin group driven from the queue |
| pin_strobe | output | 1 | Pin-side transfer strobe |
| core_req | input | 1 | Core load/store request, held until not stalled |
| core_we | input | 1 | Core request is a store |
| core_addr | input | ADDR_W | Core byte address |
| core_wdata | input | 32 | Core store data |
| core_rdata | output | 32 | Core load data, valid when served |
| core_stall | output | 1 | Core request must wait |
| ram_avail | input | 1 | The shared RAM slot belongs to this core this cycle |
| ram_req | output | 1 | RAM access this cycle |
| ram_we | output | 1 | RAM access is a write |
| ram_addr | output | ADDR_W | RAM byte address |
| ram_size | output | 2 | RAM access width code |
| ram_wdata | output | 32 | RAM write data |
| ram_rdata | input | 32 | RAM read data, valid in the cycle of the read |
| stream_addr | output | ADDR_W | Next stream RAM address |
| stream_active | output | 1 | Stream running |
| flag_ovf | output | 1 | Sticky dropped-sample flag |
| flag_unf | output | 1 | Sticky starved-strobe flag |

## Verification
The bench runs a cycle-level reference model beside the design and compares strobes, stall, every RAM access and every registered output on each cycle. It targets the case where a strobe and a drain coincide with a full queue. A design that judges fullness before the pop would set the overflow flag and lose a sample that had room. It also covers a strobe on an empty queue, where a wrong design would drive stale or zero data instead of holding the pins. A restart over a full prefetch queue must discard the old words, or the pins would replay data from the previous base. A core request during a prefetch burst must wait until the queue is full; granting it earlier would let a core access collide with the stream's reads.

// File: rtl/stream_fifo_pkg.sv
package stream_fifo_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        XS_BYTE = 2'd0,
        XS_HALF = 2'd1,
        XS_WORD = 2'd2,
        XS_WIDE = 2'd3
    } xfer_size_e;

    // Lanes kept for a transfer width; data sits in the low lanes.
    function automatic logic [WORD_W-1:0] lane_mask(input xfer_size_e sz);
        case (sz)
            XS_BYTE: lane_mask = 32'h0000_00FF;
            XS_HALF: lane_mask = 32'h0000_FFFF;
            default: lane_mask = 32'hFFFF_FFFF;
        endcase
    endfunction

    // Address advance per access for a transfer width.
    function automatic logic [2:0] lane_bytes(input xfer_size_e sz);
        case (sz)
            XS_BYTE: lane_bytes = 3'd1;
            XS_HALF: lane_bytes = 3'd2;
            default: lane_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/stream_nco.sv
module stream_nco #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [ACC_W-1:0] step_in,
    output logic             tick
);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [ACC_W-1:0] step;
    } nco_t;

    nco_t           s_d, s_q;
    logic [ACC_W:0] sum;

    always_comb begin
        s_d  = s_q;
        sum  = {1'b0, s_q.acc} + {1'b0, s_q.step};
        tick = 1'b0;
        if (load) begin
            s_d.acc  = '0;
            s_d.step = step_in;
        end else if (run) begin
            s_d.acc = sum[ACC_W-1:0];
            tick    = sum[ACC_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/stream_ring.sv
module stream_ring #(
    parameter int DEPTH = 19,
    parameter int W     = 32,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  logic             pop,
    input  logic [W-1:0]     wr_data,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] fill,
    output logic             empty,
    output logic             full
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct {
        logic [W-1:0]     slot [DEPTH];
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [CNT_W-1:0] cnt;
    } ring_t;

    ring_t r_d, r_q;
    logic  push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
        step_ptr = (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign empty = (r_q.cnt == '0);
    assign full  = (r_q.cnt == CNT_W'(DEPTH));
    assign fill  = r_q.cnt;
    assign head  = r_q.slot[r_q.rd];

    always_comb begin
        r_d     = r_q;
        pop_ok  = pop && !empty;
        push_ok = push && (!full || pop_ok);
        if (clear) begin
            r_d.rd  = '0;
            r_d.wr  = '0;
            r_d.cnt = '0;
        end else begin
            if (push_ok) begin
                r_d.slot[r_q.wr] = wr_data;
                r_d.wr           = step_ptr(r_q.wr);
            end
            if (pop_ok) begin
                r_d.rd = step_ptr(r_q.rd);
            end
            r_d.cnt = r_q.cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.rd  <= '0;
            r_q.wr  <= '0;
            r_q.cnt <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                r_q.slot[i] <= '0;
            end
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/stream_port_arb.sv
module stream_port_arb #(
    parameter int ADDR_W = 19,
    parameter int W      = 32
) (
    input  logic              ram_avail,
    input  logic              fifo_need,
    input  logic              fifo_we,
    input  logic [ADDR_W-1:0] fifo_addr,
    input  logic [1:0]        fifo_size,
    input  logic [W-1:0]      fifo_wdata,
    input  logic              core_req,
    input  logic              core_we,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [W-1:0]      core_wdata,
    output logic              ram_req,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [1:0]        ram_size,
    output logic [W-1:0]      ram_wdata,
    output logic              core_stall
);

    logic core_go;

    always_comb begin
        core_go    = core_req && ram_avail && !fifo_need;
        core_stall = core_req && !core_go;
        ram_req    = fifo_need || core_go;
        if (fifo_need) begin
            ram_we    = fifo_we;
            ram_addr  = fifo_addr;
            ram_size  = fifo_size;
            ram_wdata = fifo_wdata;
        end else begin
            ram_we    = core_go && core_we;
            ram_addr  = core_addr;
            ram_size  = 2'd2;
            ram_wdata = core_wdata;
        end
    end

endmodule

// File: rtl/stream_fifo_arb.sv
module stream_fifo_arb
    import stream_fifo_pkg::*;
#(
    parameter int DEPTH  = 19,
    parameter int ADDR_W = 19,
    parameter int ACC_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              cfg_to_ram,
    input  logic [1:0]        cfg_size,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ACC_W-1:0]  cfg_step,
    input  logic [31:0]       pin_in,
    output logic [31:0]       pin_out,
    output logic              pin_strobe,
    input  logic              core_req,
    input  logic              core_we,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [31:0]       core_wdata,
    output logic [31:0]       core_rdata,
    output logic              core_stall,
    input  logic              ram_avail,
    output logic              ram_req,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [1:0]        ram_size,
    output logic [31:0]       ram_wdata,
    input  logic [31:0]       ram_rdata,
    output logic [ADDR_W-1:0] stream_addr,
    output logic              stream_active,
    output logic              flag_ovf,
    output logic              flag_unf
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic              active;
        logic              to_ram;
        xfer_size_e        size;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] pin;
        logic              ovf;
        logic              unf;
    } ctl_t;

    ctl_t              c_d, c_q;
    logic              running, tick, fifo_need;
    logic              ring_push, ring_pop, ring_empty, ring_full;
    logic [WORD_W-1:0] ring_head, ring_wdata, lane;
    logic [CNT_W-1:0]  fill;

    assign running = c_q.active && !cmd_start;

    stream_nco #(.ACC_W(ACC_W)) u_nco (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (cmd_start),
        .run    (running),
        .step_in(cfg_step),
        .tick   (tick)
    );

    stream_ring #(.DEPTH(DEPTH), .W(WORD_W), .CNT_W(CNT_W)) u_ring (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (cmd_start),
        .push   (ring_push),
        .pop    (ring_pop),
        .wr_data(ring_wdata),
        .head   (ring_head),
        .fill   (fill),
        .empty  (ring_empty),
        .full   (ring_full)
    );

    stream_port_arb #(.ADDR_W(ADDR_W), .W(WORD_W)) u_arb (
        .ram_avail (ram_avail),
        .fifo_need (fifo_need),
        .fifo_we   (c_q.to_ram),
        .fifo_addr (c_q.addr),
        .fifo_size (c_q.size),
        .fifo_wdata(ring_head),
        .core_req  (core_req),
        .core_we   (core_we),
        .core_addr (core_addr),
        .core_wdata(core_wdata),
        .ram_req   (ram_req),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_size  (ram_size),
        .ram_wdata (ram_wdata),
        .core_stall(core_stall)
    );

    always_comb begin
        c_d       = c_q;
        lane      = lane_mask(c_q.size);
        fifo_need = running && ram_avail &&
                    (c_q.to_ram ? !ring_empty : !ring_full);
        if (c_q.to_ram) begin
            ring_pop   = fifo_need;
            ring_push  = tick;
            ring_wdata = pin_in & lane;
        end else begin
            ring_pop   = tick && !ring_empty;
            ring_push  = fifo_need;
            ring_wdata = ram_rdata & lane;
        end

        if (cmd_start) begin
            c_d.active = 1'b1;
            c_d.to_ram = cfg_to_ram;
            c_d.size   = xfer_size_e'(cfg_size);
            c_d.addr   = cfg_base;
            c_d.ovf    = 1'b0;
            c_d.unf    = 1'b0;
        end else begin
            if (fifo_need) begin
                c_d.addr = c_q.addr + ADDR_W'(lane_bytes(c_q.size));
            end
            if (tick && c_q.to_ram && ring_full && !ring_pop) begin
                c_d.ovf = 1'b1;
            end
            if (tick && !c_q.to_ram) begin
                if (ring_empty) begin
                    c_d.unf = 1'b1;
                end else begin
                    c_d.pin = ring_head;
                end
            end
            if (cmd_stop) begin
                c_d.active = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign pin_out       = c_q.pin;
    assign pin_strobe    = tick;
    assign core_rdata    = ram_rdata;
    assign stream_addr   = c_q.addr;
    assign stream_active = c_q.active;
    assign flag_ovf      = c_q.ovf;
    assign flag_unf      = c_q.unf;

endmodule

// File: rtl/stream_fifo_arb_chk.sv
module stream_fifo_arb_chk #(
    parameter int DEPTH = 19,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_start,
    input logic             ram_avail,
    input logic             core_req,
    input logic             core_stall,
    input logic             ram_req,
    input logic             pin_strobe,
    input logic             stream_active,
    input logic             flag_ovf,
    input logic             flag_unf,
    input logic [CNT_W-1:0] fill,
    input logic             fifo_need
);

    // R8: no slot means the core waits
    a_r8_no_slot_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req && !ram_avail) |-> core_stall);

    // R8: a stream access owns the port and holds off the core
    a_r8_stream_first: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_need |-> (ram_req && (!core_req || core_stall)));

    // R6: queue never exceeds its depth
    a_r6_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(DEPTH));

    // R6: overflow flag is sticky until a start
    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_ovf && !cmd_start) |=> flag_ovf);

    // R7: underflow flag is sticky until a start
    a_r7_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_unf && !cmd_start) |=> flag_unf);

    // R2: no strobe while idle or starting
    a_r2_no_idle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!stream_active || cmd_start) |-> !pin_strobe);

    // R11: an idle stream issues no RAM traffic of its own
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!stream_active && !core_req) |-> !ram_req);

    // R10: start empties the queue and clears flags
    a_r10_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> (fill == '0 && !flag_ovf && !flag_unf && stream_active));

endmodule

bind stream_fifo_arb stream_fifo_arb_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_start    (cmd_start),
    .ram_avail    (ram_avail),
    .core_req     (core_req),
    .core_stall   (core_stall),
    .ram_req      (ram_req),
    .pin_strobe   (pin_strobe),
    .stream_active(stream_active),
    .flag_ovf     (flag_ovf),
    .flag_unf     (flag_unf),
    .fill         (fill),
    .fifo_need    (fifo_need)
);

// File: tb/stream_fifo_arb_bench.sv
module stream_fifo_arb_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 19;
    localparam int ADDR_W     = 19;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_start = 1'b0, cmd_stop = 1'b0, cfg_to_ram = 1'b0;
    logic [1:0]        cfg_size = 2'd2;
    logic [ADDR_W-1:0] cfg_base = '0;
    logic [31:0]       cfg_step = '0;
    logic [31:0]       pin_in = 32'h1234_5678;
    logic [31:0]       pin_out;
    logic              pin_strobe;
    logic              core_req = 1'b0, core_we = 1'b0;
    logic [ADDR_W-1:0] core_addr = '0;
    logic [31:0]       core_wdata = '0, core_rdata;
    logic              core_stall;
    logic              ram_avail = 1'b0;
    logic              ram_req, ram_we;
    logic [ADDR_W-1:0] ram_addr, stream_addr;
    logic [1:0]        ram_size;
    logic [31:0]       ram_wdata, ram_rdata;
    logic              stream_active, flag_ovf, flag_unf;

    int n_checks = 0, n_fail = 0, cycles = 0, avail_mode = 0;
    bit done = 1'b0;

    logic [7:0] mem [4096];

    stream_fifo_arb #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .ACC_W(32)) u_stream_fifo_arb (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [31:0] mask_of(input logic [1:0] s);
        return (s == 2'd0) ? 32'hFF : (s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic int bytes_of(input logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] rd_mem(input logic [ADDR_W-1:0] a, input logic [1:0] s);
        logic [31:0] v = '0;
        for (int i = 0; i < bytes_of(s); i++) v[8*i +: 8] = mem[(int'(a) + i) % 4096];
        return v;
    endfunction

    // bench RAM: read data valid in the cycle of the read
    always_comb ram_rdata = rd_mem(ram_addr, ram_size);
    always @(posedge clk) begin
        if (ram_req && ram_we)
            for (int i = 0; i < bytes_of(ram_size); i++)
                mem[(int'(ram_addr) + i) % 4096] <= ram_wdata[8*i +: 8];
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    // ---------------- reference model ----------------
    logic              m_active = 0, m_to_ram = 0, m_ovf = 0, m_unf = 0;
    logic [1:0]        m_size = 0;
    logic [ADDR_W-1:0] m_addr = 0;
    logic [31:0]       m_acc = 0, m_step = 0, m_pin = 0;
    logic [31:0]       mq[$];

    task automatic model_step();
        int          cnt0;
        logic [32:0] sum;
        bit          run, tick, need, go;
        if (!rst_n) begin
            m_active = 0; m_to_ram = 0; m_ovf = 0; m_unf = 0; m_size = 0;
            m_addr = 0; m_acc = 0; m_step = 0; m_pin = 0; mq.delete();
            return;
        end
        chk(pin_out == m_pin, "R5/R7", "pin_out", pin_out, m_pin);
        chk(flag_ovf == m_ovf, "R6", "flag_ovf", 32'(flag_ovf), 32'(m_ovf));
        chk(flag_unf == m_unf, "R7", "flag_unf", 32'(flag_unf), 32'(m_unf));
        chk(stream_addr == m_addr, "R3", "stream_addr", 32'(stream_addr), 32'(m_addr));
        chk(stream_active == m_active, "R11", "stream_active", 32'(stream_active), 32'(m_active));
        cnt0 = mq.size();
        sum  = {1'b0, m_acc} + {1'b0, m_step};
        run  = m_active && !cmd_start;
        tick = run && sum[32];
        need = run && ram_avail && (m_to_ram ? (cnt0 > 0) : (cnt0 < DEPTH));
        go   = core_req && ram_avail && !need;
        chk(pin_strobe == tick, "R2", "pin_strobe", 32'(pin_strobe), 32'(tick));
        chk(core_stall == (core_req && !go), "R8", "core_stall", 32'(core_stall), 32'(core_req && !go));
        chk(ram_req == (need || go), "R8", "ram_req", 32'(ram_req), 32'(need || go));
        if (need) begin
            chk(ram_we == m_to_ram, "R4/R5", "stream ram_we", 32'(ram_we), 32'(m_to_ram));
            chk(ram_addr == m_addr, "R3", "stream ram_addr", 32'(ram_addr), 32'(m_addr));
            chk(ram_size == m_size, "R3", "stream ram_size", 32'(ram_size), 32'(m_size));
            if (m_to_ram) chk(ram_wdata == mq[0], "R4", "stream ram_wdata", ram_wdata, mq[0]);
        end
        if (go) begin
            chk(ram_we == core_we && ram_addr == core_addr && ram_size == 2'd2,
                "R9", "core access addr", 32'(ram_addr), 32'(core_addr));
            if (core_we) chk(ram_wdata == core_wdata, "R9", "core wdata", ram_wdata, core_wdata);
            else chk(core_rdata == rd_mem(core_addr, 2'd2), "R9", "core rdata", core_rdata, rd_mem(core_addr, 2'd2));
        end
        if (cmd_start) begin
            m_active = 1; m_to_ram = cfg_to_ram; m_size = cfg_size; m_addr = cfg_base;
            m_step = cfg_step; m_acc = 0; m_ovf = 0; m_unf = 0; mq.delete();
        end else begin
            if (m_to_ram) begin
                if (need) void'(mq.pop_front());
                if (tick) begin
                    if (cnt0 < DEPTH || need) mq.push_back(pin_in & mask_of(m_size));
                    else m_ovf = 1;
                end
            end else begin
                if (tick) begin
                    if (cnt0 > 0) m_pin = mq.pop_front();
                    else m_unf = 1;
                end
                if (need) mq.push_back(rd_mem(m_addr, m_size) & mask_of(m_size));
            end
            if (need) m_addr = m_addr + ADDR_W'(bytes_of(m_size));
            if (run) m_acc = sum[31:0];
            if (cmd_stop) m_active = 0;
        end
    endtask

    always begin
        @(negedge clk);
        #3;
        if (!done) model_step();
    end

    // ---------------- stimulus drivers ----------------
    initial begin
        forever begin
            @(negedge clk);
            cycles++;
            pin_in = pin_in * 32'd1103515245 + 32'd12345;
            case (avail_mode)
                0:       ram_avail = 1'b0;
                1:       ram_avail = 1'b1;
                default: ram_avail = (cycles % 3) != 0;
            endcase
        end
    end

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_stream(input logic dir, input logic [1:0] sz,
                                input logic [ADDR_W-1:0] base, input logic [31:0] step);
        @(negedge clk);
        cmd_start = 1; cfg_to_ram = dir; cfg_size = sz; cfg_base = base; cfg_step = step;
        @(negedge clk);
        cmd_start = 0;
    endtask

    task automatic stop_stream();
        @(negedge clk);
        cmd_stop = 1;
        @(negedge clk);
        cmd_stop = 0;
    endtask

    task automatic core_access(input logic we, input logic [ADDR_W-1:0] a,
                               input logic [31:0] wd, output logic [31:0] rd, output int waits);
        @(negedge clk);
        core_req = 1; core_we = we; core_addr = a; core_wdata = wd;
        waits = 0;
        rd = '0;
        for (int k = 0; k < 500; k++) begin
            #3;
            if (!core_stall) begin
                rd = core_rdata;
                break;
            end
            waits++;
            @(negedge clk);
        end
        @(negedge clk);
        core_req = 0;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        @(negedge clk);
        #3;
        chk(!stream_active && !ram_req && !pin_strobe, "R1", "idle after reset", 32'(ram_req), 0);
        chk(pin_out == 0 && stream_addr == 0, "R1", "pin_out/stream_addr zero", pin_out, 0);
        chk(!flag_ovf && !flag_unf, "R1", "flags clear", 32'({flag_ovf, flag_unf}), 0);
    endtask

    task automatic t_core_idle();
        logic [31:0] rd;
        int w;
        avail_mode = 1;
        core_access(1, 19'h300, 32'hCAFE_F00D, rd, w);
        core_access(0, 19'h300, 32'h0, rd, w);
        chk(rd == 32'hCAFE_F00D, "R9", "idle core read-back", rd, 32'hCAFE_F00D);
        chk(w == 0, "R9", "idle core waits", 32'(w), 0);
    endtask

    task automatic t_p2r_word();
        logic [31:0] rd;
        int w;
        avail_mode = 1;
        start_stream(1, 2'd2, 19'h400, 32'h8000_0000);
        wait_cycles(10);
        core_access(1, 19'h380, 32'h0BAD_BEEF, rd, w);
        wait_cycles(30);
        stop_stream();
        wait_cycles(2);
        #3;
        chk(stream_addr != 19'h400, "R4", "stream advanced", 32'(stream_addr), 32'h400);
    endtask

    task automatic t_p2r_byte();
        logic [ADDR_W-1:0] a0;
        avail_mode = 2;
        start_stream(1, 2'd0, 19'h500, 32'h6000_0000);
        wait_cycles(40);
        stop_stream();
        @(negedge clk);
        #3;
        a0 = stream_addr;
        wait_cycles(5);
        #3;
        chk(stream_addr == a0, "R11", "stream_addr holds after stop", 32'(stream_addr), 32'(a0));
        chk(!stream_active, "R11", "inactive after stop", 32'(stream_active), 0);
    endtask

    task automatic t_overflow();
        avail_mode = 0;
        start_stream(1, 2'd2, 19'h600, 32'hF000_0000);
        wait_cycles(40);
        #3;
        chk(flag_ovf, "R6", "overflow flagged", 32'(flag_ovf), 1);
        avail_mode = 1;
        wait_cycles(40);
        stop_stream();
        wait_cycles(2);
    endtask

    task automatic t_r2p_half();
        logic [31:0] rd;
        int w;
        avail_mode = 1;
        start_stream(0, 2'd1, 19'h100, 32'h2000_0000);
        core_access(0, 19'h010, 32'h0, rd, w);
        chk(w > 0, "R8", "core stalled by prefetch", 32'(w), 1);
        chk(rd == rd_mem(19'h010, 2'd2), "R9", "core read during stream", rd, rd_mem(19'h010, 2'd2));
        wait_cycles(60);
    endtask

    task automatic t_restart();
        logic [31:0] hold;
        start_stream(0, 2'd2, 19'h700, 32'hFFFF_FFFF);
        @(negedge clk);
        #3;
        chk(!flag_unf && !flag_ovf, "R10", "flags cleared by start", 32'(flag_unf), 0);
        avail_mode = 0;
        start_stream(0, 2'd2, 19'h780, 32'hC000_0000);
        @(negedge clk);
        #3;
        hold = pin_out;
        wait_cycles(4);
        #3;
        chk(flag_unf, "R7", "underflow flagged", 32'(flag_unf), 1);
        chk(pin_out == hold, "R7", "pin_out held on empty strobe", pin_out, hold);
        avail_mode = 2;
        wait_cycles(50);
        stop_stream();
        wait_cycles(3);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7 + 3);
        wait_cycles(3);
        rst_n = 1;
        t_reset();
        t_core_idle();
        t_p2r_word();
        t_p2r_byte();
        t_overflow();
        t_r2p_half();
        t_restart();
        wait_cycles(2);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule